// File: doc/BRIEF.md
# Multi-mode buzzer tone driver

This block drives a piezo buzzer pin with a 50% duty square tone. A start strobe captures a 2-bit tone-rate field and a 2-bit pattern field and begins a sequence. Depending on the pattern, the tone is either gated at 8 Hz, gated at 8 Hz inside a 1 Hz envelope, emitted as one short burst, or emitted without interruption. A stop strobe ends any sequence. The single-burst pattern also ends by itself.

All timing is taken from the system clock. The `CLK_HZ` parameter gives its rate, and its default is 4.096 MHz. Each duration below is stated in clocks as a fraction of `CLK_HZ`. The clock count measured from a start is called n, and n is 0 in the first cycle after the start edge.

Top module: `buzzer_drv`

## Requirements
- R1: After reset, `buz_out` is 0 and `busy_n` is 1. Whenever `busy_n` is 1, `buz_out` is 0.
- R2: A start strobe without stop captures `mode` and `freq`, drives `busy_n` low in the next cycle and restarts every timer. `buz_out` is high at n=0 in every pattern. A start during an active sequence restarts it from n=0.
- R3: The tone half period is selected by `freq`. The value 00 gives CLK_HZ/1000 clocks (0.5 kHz), 01 gives CLK_HZ/2000 clocks (1 kHz), and 10 or 11 give CLK_HZ/4000 clocks (2 kHz). The tone is high in even half periods counted from n=0.
- R4: Pattern `mode`=11 is continuous. The tone runs ungated until a stop arrives.
- R5: Pattern `mode`=00 gates the tone at 8 Hz. The tone is passed while (n / (CLK_HZ/16)) is even and silenced while it is odd.
- R6: Pattern `mode`=01 applies the 8 Hz gate of R5 only during the first half of each second, where (n / (CLK_HZ/16)) mod 16 < 8. The tone is silent for the other half, and the pattern repeats every CLK_HZ clocks.
- R7: Pattern `mode`=10 is single. The tone plays ungated for CLK_HZ/64 clocks, from n=0 through n=CLK_HZ/64-1. After that `busy_n` returns to 1 without any stop.
- R8: A stop strobe makes the block idle in the next cycle (R1 state). Stop takes priority over a simultaneous start.
- R9: Changes on `mode` and `freq` while a sequence is active, without a new start, have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, captures mode and freq |
| stop | input | 1 | Stop strobe, ends the sequence |
| mode | input | 2 | Gating pattern select |
| freq | input | 2 | Tone rate select |
| buz_out | output | 1 | Buzzer drive |
| busy_n | output | 1 | Low while a sequence is active |

## Verification
The bench follows whole 1 s cycles of the two-level envelope. This catches a design that swaps the silent and gated halves, or one that leaks tone into the silent half. The single burst is checked at its exact last cycle, so a burst that is one cycle short or long shows up as a wrong `busy_n`. The bench also drives stop and start together, which catches a design that gives start priority, and restarts the block mid-sequence, which catches timers that are not cleared. During runs it scrambles `mode` and `freq`, so logic that reads the live inputs instead of the captured values produces tones at the wrong rate.

// File: rtl/buzzer_drv.sv
module buzzer_drv #(
  parameter int CLK_HZ = 4096000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  logic [1:0] mode,
  input  logic [1:0] freq,
  output logic       buz_out,
  output logic       busy_n
);
  localparam int HALF_FAST = CLK_HZ / 4000;
  localparam int ENV8      = CLK_HZ / 16;
  localparam int BURST     = CLK_HZ / 64;
  localparam int TW        = $clog2(4 * HALF_FAST);
  localparam int EW        = $clog2(ENV8);

  logic          active;
  logic [1:0]    mode_q, freq_q;
  logic [TW-1:0] tcnt, half_lim;
  logic          tph;
  logic [EW-1:0] ecnt;
  logic [3:0]    tog;
  logic          gate;

  always_comb begin
    case (freq_q)
      2'b00:   half_lim = TW'(4 * HALF_FAST - 1);
      2'b01:   half_lim = TW'(2 * HALF_FAST - 1);
      default: half_lim = TW'(HALF_FAST - 1);
    endcase
    case (mode_q)
      2'b00:   gate = ~tog[0];
      2'b01:   gate = ~tog[0] & ~tog[3];
      default: gate = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode_q <= '0;
      freq_q <= '0;
      tcnt   <= '0;
      tph    <= 1'b0;
      ecnt   <= '0;
      tog    <= '0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      mode_q <= mode;
      freq_q <= freq;
      tcnt   <= '0;
      tph    <= 1'b1;
      ecnt   <= '0;
      tog    <= '0;
    end else if (active) begin
      if (tcnt == half_lim) begin
        tcnt <= '0;
        tph  <= ~tph;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
      if (ecnt == EW'(ENV8 - 1)) begin
        ecnt <= '0;
        tog  <= tog + 1'b1;
      end else begin
        ecnt <= ecnt + 1'b1;
      end
      if (mode_q == 2'b10 && tog == 4'd0 && ecnt == EW'(BURST - 1))
        active <= 1'b0;
    end
  end

  assign buz_out = active & tph & gate;
  assign busy_n  = ~active;
endmodule

// File: rtl/buzzer_drv_chk.sv
module buzzer_drv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       stop,
  input logic       buz_out,
  input logic       busy_n,
  input logic [1:0] mode_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !buz_out);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> !busy_n);

  assert_cont_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && mode_q == 2'b11 && !stop) |=> !busy_n);

  assert_self_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> ($past(stop) || $past(mode_q) == 2'b10));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (busy_n && !buz_out));
endmodule

bind buzzer_drv buzzer_drv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .buz_out(buz_out), .busy_n(busy_n), .mode_q(mode_q)
);

// File: tb/test_buzzer_drv.sv
module test_buzzer_drv;
  localparam int CLK_HZ = 32000;
  localparam int ENV8   = CLK_HZ / 16;
  localparam int BURST  = CLK_HZ / 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic [1:0] mode = '0, freq = '0;
  logic buz_out, busy_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  buzzer_drv #(.CLK_HZ(CLK_HZ)) i_buzzer_drv (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .mode(mode), .freq(freq), .buz_out(buz_out), .busy_n(busy_n)
  );

  always #4 clk = ~clk;

  function automatic int half_of(input logic [1:0] f);
    return (f == 2'b00) ? CLK_HZ / 1000 : (f == 2'b01) ? CLK_HZ / 2000 : CLK_HZ / 4000;
  endfunction

  function automatic logic exp_busy_n(input logic [1:0] m, input int n);
    return (m == 2'b10) ? (n >= BURST) : 1'b0;
  endfunction

  function automatic logic exp_out(input logic [1:0] m, input logic [1:0] f, input int n);
    int t;
    logic ph, g;
    t  = (n / ENV8) % 16;
    ph = ((n / half_of(f)) % 2) == 0;
    case (m)
      2'b00:   g = (t % 2) == 0;
      2'b01:   g = ((t % 2) == 0) && (t < 8);
      2'b10:   g = n < BURST;
      default: g = 1'b1;
    endcase
    return ph & g;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input int n);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s n=%0d actual=%0b expected=%0b", req, n, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [1:0] f, input int cycles,
                     input bit scramble, input string req);
    @(negedge clk);
    start = 1'b1; mode = m; freq = f;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      check(req, buz_out, exp_out(m, f, n), n);
      check(req, busy_n, exp_busy_n(m, n), n);
      if (scramble && (n % 97 == 0)) begin  // R9
        mode = 2'($urandom);
        freq = 2'($urandom);
      end
      @(negedge clk);
    end
  endtask

  task automatic do_stop(input string req);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(req, busy_n, 1'b1, -1);
    check(req, buz_out, 1'b0, -1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", buz_out, 1'b0, 0);
    check("R1", busy_n, 1'b1, 0);

    run(2'b11, 2'b00, 300, 1'b0, "R3_R4");
    run(2'b11, 2'b01, 200, 1'b0, "R2_R3");
    run(2'b11, 2'b11, 100, 1'b0, "R3");
    do_stop("R8");

    run(2'b00, 2'b10, 5000, 1'b0, "R5");
    do_stop("R8");

    run(2'b01, 2'b01, 33000, 1'b1, "R6_R9");
    do_stop("R8");

    run(2'b10, 2'b00, BURST + 50, 1'b0, "R7");
    run(2'b10, 2'b10, BURST + 5, 1'b1, "R7_R9");

    run(2'b11, 2'b10, 150, 1'b0, "R2");
    run(2'b00, 2'b00, 4500, 1'b0, "R2_R5");
    do_stop("R8");

    @(negedge clk);
    start = 1'b1; stop = 1'b1; mode = 2'b11;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    check("R8", busy_n, 1'b1, 0);
    check("R8", buz_out, 1'b0, 0);

    for (int k = 0; k < 8; k++) begin
      run(2'($urandom), 2'($urandom), 1000 + ($urandom % 3000), 1'b1, "R3_R9");
      if ($urandom % 2) do_stop("R8");
    end
    do_stop("R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule